// File: doc/BRIEF.md
# Mode-Banked Dual Stack Pointer

This block holds the two 32-bit stack pointers of a processor core. Neither physical register is tied to supervisor or user meaning. One acts as the active stack pointer and the other as the inactive one. A registered supervisor bit decides which privilege level the active pointer belongs to. When that bit changes, the contents of the two views exchange in a single clock edge, so the core always sees the pointer of its current mode through one read/write port.

A debug port reads and writes the raw active and inactive views by selector, with no translation by mode. The debug host works out which view is the supervisor pointer and which is the user pointer from the mode bit, which the block exports. A core write and a debug write in the same cycle are both resolved in that cycle. A debug write to the active view takes priority over a core write to it.

Top module: `sp_bank_top`

## Requirements
- R1: While reset is held, at the first clock edge both views clear to zero and the supervisor bit `sup_o` becomes 1. The debug read selector also returns to the active view.
- R2: `core_rdata` shows the current contents of the active view combinationally, with no added latency.
- R3: A core write (`core_we`=1) updates the active view at the next clock edge, unless a debug write to the active view happens in the same cycle.
- R4: When `mode_stb`=1 and `mode_sup` differs from `sup_o`, the active and inactive contents exchange at that edge and `sup_o` takes the new value.
- R5: The block ignores `mode_sup` when `mode_stb`=0. A strobe whose value equals `sup_o` changes neither `sup_o` nor the contents.
- R6: The debug selector encodes 0 as the active view and 1 as the inactive view. A debug write (`dbg_we`=1) updates the selected view at the next edge.
- R7: When a core write and a debug write with `dbg_sel`=0 occur in the same cycle, the active view takes `dbg_wdata`.
- R8: A debug write to the inactive view and a core write to the active view in the same cycle both take effect.
- R9: Writes in a cycle that also swaps apply to the post-swap views. For example, a core write lands in the register that has just become active.
- R10: `dbg_rdata` in a cycle returns the view selected by `dbg_sel` one cycle earlier. It reads the contents as they stand after that edge's swap and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_we | input | 1 | Core write strobe for the active view |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Active view contents |
| mode_stb | input | 1 | Mode update strobe |
| mode_sup | input | 1 | New supervisor bit, sampled with `mode_stb` |
| sup_o | output | 1 | Current supervisor bit |
| dbg_we | input | 1 | Debug write strobe |
| dbg_sel | input | 1 | Debug view selector: 0 active, 1 inactive |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rdata | output | DATA_W | Debug read data, one cycle after selection |

## Verification
`core_rdata` follows the active view with zero latency. Writes, swaps and `sup_o` changes show up exactly one edge after the stimulus. `dbg_rdata` reflects the selector of the previous cycle, applied to the contents after that edge.

The bench sweeps every combination of core write, debug write, selector, strobe and mode value, repeated with changing data. It drives each vector on the falling edge and updates an arithmetic model at the rising edge. It then compares all three outputs at the following falling edge, so each result is sampled in the cycle it is due.

// File: rtl/sp_bank_pkg.sv
// Shared types for the banked stack pointer block.
// Assumes a single-bit view selector on the debug side.
package sp_bank_pkg;

    // Debug view selector encoding
    typedef enum logic {
        VIEW_ACTIVE = 1'b0,
        VIEW_OTHER  = 1'b1
    } sp_view_e;

endpackage

// File: rtl/sp_mode_ctrl.sv
// Holds the supervisor bit and flags a bank exchange when a strobed
// mode value differs from the stored one.
// Assumes: synchronous active-low reset, supervisor mode after reset.
module sp_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_stb,
    input  logic mode_sup,
    output logic sup_q,
    output logic swap
);

    // Exchange request: strobe carrying a different mode value
    always_comb begin
        swap = mode_stb && (mode_sup != sup_q);
    end

    // Supervisor bit register, resets into supervisor mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_q <= 1'b1;
        end else if (swap) begin
            sup_q <= mode_sup;
        end
    end

endmodule

// File: rtl/sp_write_mux.sv
// Resolves core and debug writes into per-view write requests.
// Debug beats core on the active view; writes target post-swap views.
// Assumes: at most one core and one debug write per cycle.
module sp_write_mux
    import sp_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              dbg_we,
    input  sp_view_e          dbg_view,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic              act_we,
    output logic [DATA_W-1:0] act_wdata,
    output logic              oth_we,
    output logic [DATA_W-1:0] oth_wdata
);

    logic dbg_act;
    logic dbg_oth;

    // Decode debug target view
    always_comb begin
        dbg_act = dbg_we && (dbg_view == VIEW_ACTIVE);
        dbg_oth = dbg_we && (dbg_view == VIEW_OTHER);
    end

    // Active view: debug has priority over core
    always_comb begin
        act_we    = dbg_act || core_we;
        act_wdata = dbg_act ? dbg_wdata : core_wdata;
    end

    // Inactive view: only the debug side writes it
    always_comb begin
        oth_we    = dbg_oth;
        oth_wdata = dbg_wdata;
    end

endmodule

// File: rtl/sp_bank_store.sv
// Storage for the two stack pointer views. RENAME_BANKS picks the
// implementation: 0 moves contents on an exchange, 1 flips a bank pointer.
// Both present identical active/inactive views.
// Assumes: writes in an exchange cycle address the post-exchange views.
module sp_bank_store #(
    parameter int DATA_W       = 32,
    parameter bit RENAME_BANKS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap,
    input  logic              act_we,
    input  logic [DATA_W-1:0] act_wdata,
    input  logic              oth_we,
    input  logic [DATA_W-1:0] oth_wdata,
    output logic [DATA_W-1:0] act_val,
    output logic [DATA_W-1:0] oth_val
);

    localparam int NBANK = 2;

    generate
        if (RENAME_BANKS == 1'b0) begin : g_move
            logic [DATA_W-1:0] act_q;
            logic [DATA_W-1:0] oth_q;
            logic [DATA_W-1:0] act_d;
            logic [DATA_W-1:0] oth_d;

            // Next state: exchange first, then apply writes
            always_comb begin
                act_d = swap ? oth_q : act_q;
                oth_d = swap ? act_q : oth_q;
                if (act_we) act_d = act_wdata;
                if (oth_we) oth_d = oth_wdata;
            end

            // View registers
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    act_q <= '0;
                    oth_q <= '0;
                end else begin
                    act_q <= act_d;
                    oth_q <= oth_d;
                end
            end

            // Expose views
            always_comb begin
                act_val = act_q;
                oth_val = oth_q;
            end
        end else begin : g_rename
            logic [DATA_W-1:0] bank_q [NBANK];
            logic              ptr_q;
            logic              ptr_d;

            // Pointer after any exchange this cycle
            always_comb begin
                ptr_d = ptr_q ^ swap;
            end

            // Bank pointer register
            always_ff @(posedge clk) begin
                if (!rst_n) ptr_q <= 1'b0;
                else        ptr_q <= ptr_d;
            end

            // Bank registers, addressed through the post-exchange pointer
            for (genvar b = 0; b < NBANK; b++) begin : g_bank
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        bank_q[b] <= '0;
                    end else if (act_we && (ptr_d == 1'(b))) begin
                        bank_q[b] <= act_wdata;
                    end else if (oth_we && (ptr_d != 1'(b))) begin
                        bank_q[b] <= oth_wdata;
                    end
                end
            end

            // Expose views through the current pointer
            always_comb begin
                act_val = bank_q[ptr_q];
                oth_val = bank_q[~ptr_q];
            end
        end
    endgenerate

endmodule

// File: rtl/sp_bank_top.sv
// Mode-banked stack pointer pair: core port on the active view,
// debug port on either raw view, supervisor bit with exchange on change.
// Assumes: synchronous active-low reset; debug read latency of one cycle.
module sp_bank_top
    import sp_bank_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter bit RENAME_BANKS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              mode_stb,
    input  logic              mode_sup,
    output logic              sup_o,
    input  logic              dbg_we,
    input  logic              dbg_sel,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata
);

    logic              swap;
    logic              act_we;
    logic [DATA_W-1:0] act_wdata;
    logic              oth_we;
    logic [DATA_W-1:0] oth_wdata;
    logic [DATA_W-1:0] act_val;
    logic [DATA_W-1:0] oth_val;
    sp_view_e          dbg_view;
    sp_view_e          rd_view_q;

    // Map raw selector onto the view type
    always_comb begin
        dbg_view = sp_view_e'(dbg_sel);
    end

    sp_mode_ctrl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_stb (mode_stb),
        .mode_sup (mode_sup),
        .sup_q    (sup_o),
        .swap     (swap)
    );

    sp_write_mux #(.DATA_W(DATA_W)) u_wmux (
        .core_we    (core_we),
        .core_wdata (core_wdata),
        .dbg_we     (dbg_we),
        .dbg_view   (dbg_view),
        .dbg_wdata  (dbg_wdata),
        .act_we     (act_we),
        .act_wdata  (act_wdata),
        .oth_we     (oth_we),
        .oth_wdata  (oth_wdata)
    );

    sp_bank_store #(.DATA_W(DATA_W), .RENAME_BANKS(RENAME_BANKS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (swap),
        .act_we    (act_we),
        .act_wdata (act_wdata),
        .oth_we    (oth_we),
        .oth_wdata (oth_wdata),
        .act_val   (act_val),
        .oth_val   (oth_val)
    );

    // Register the debug read selector for one-cycle read latency
    always_ff @(posedge clk) begin
        if (!rst_n) rd_view_q <= VIEW_ACTIVE;
        else        rd_view_q <= dbg_view;
    end

    // Output views
    always_comb begin
        core_rdata = act_val;
        dbg_rdata  = (rd_view_q == VIEW_OTHER) ? oth_val : act_val;
    end

endmodule

// File: rtl/sp_bank_chk.sv
// Assertion checker for sp_bank_top, attached by bind below.
// Assumes reset is asserted at the first clock edge.
module sp_bank_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_we,
    input logic [DATA_W-1:0] core_wdata,
    input logic [DATA_W-1:0] core_rdata,
    input logic              mode_stb,
    input logic              mode_sup,
    input logic              sup_o,
    input logic              dbg_we,
    input logic              dbg_sel,
    input logic [DATA_W-1:0] dbg_wdata,
    input logic [DATA_W-1:0] dbg_rdata,
    input logic [DATA_W-1:0] oth_val
);

    logic was_rst = 1'b0;

    // Remember that the previous edge was a reset edge
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (core_rdata == '0 && oth_val == '0 && sup_o));

    assert_core_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we && !(dbg_we && !dbg_sel)) |=> core_rdata == $past(core_wdata));

    assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stb && mode_sup != sup_o && !core_we && !dbg_we)
        |=> (core_rdata == $past(oth_val) && oth_val == $past(core_rdata)
             && sup_o == $past(mode_sup)));

    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_stb && mode_sup != sup_o) |=> $stable(sup_o));

    assert_dbg_other_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_we && dbg_sel) |=> oth_val == $past(dbg_wdata));

    assert_dbg_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_we && !dbg_sel) |=> core_rdata == $past(dbg_wdata));

    assert_dbg_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !was_rst |=> dbg_rdata == ($past(dbg_sel) ? oth_val : core_rdata));

endmodule

bind sp_bank_top sp_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_we    (core_we),
    .core_wdata (core_wdata),
    .core_rdata (core_rdata),
    .mode_stb   (mode_stb),
    .mode_sup   (mode_sup),
    .sup_o      (sup_o),
    .dbg_we     (dbg_we),
    .dbg_sel    (dbg_sel),
    .dbg_wdata  (dbg_wdata),
    .dbg_rdata  (dbg_rdata),
    .oth_val    (oth_val)
);

// File: tb/sim_sp_bank_top.sv
`timescale 1ns/1ps
module sim_sp_bank_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         core_we = 1'b0;
    logic [W-1:0] core_wdata = '0;
    logic [W-1:0] core_rdata;
    logic         mode_stb = 1'b0;
    logic         mode_sup = 1'b0;
    logic         sup_o;
    logic         dbg_we = 1'b0;
    logic         dbg_sel = 1'b0;
    logic [W-1:0] dbg_wdata = '0;
    logic [W-1:0] dbg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [W-1:0] m_act;
    logic [W-1:0] m_oth;
    logic         m_sup;

    always #2.5 clk = ~clk;

    sp_bank_top #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .core_we(core_we), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .mode_stb(mode_stb), .mode_sup(mode_sup), .sup_o(sup_o),
        .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] a_old;
        string tag;
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 core_rdata", core_rdata, '0);
        check("R1 sup_o", {31'b0, sup_o}, 32'd1);
        check("R1 dbg_rdata", dbg_rdata, '0);
        rst_n = 1'b1;
        m_act = '0; m_oth = '0; m_sup = 1'b1;
        for (int rep = 0; rep < 8; rep++) begin
            for (int c = 0; c < 32; c++) begin
                core_we    = c[0];
                dbg_we     = c[1];
                dbg_sel    = c[2];
                mode_stb   = c[3];
                mode_sup   = c[4] ^ rep[0];
                core_wdata = (32'(rep * 32 + c) * 32'h0101_0101) ^ 32'hA5A5_0000;
                dbg_wdata  = ~core_wdata + 32'(c);
                #0.5;
                // R2: combinational view before the edge
                check("R2 core_rdata", core_rdata, m_act);
                @(posedge clk);
                // Model: exchange (R4/R5), then writes on post-exchange views (R9)
                if (mode_stb && mode_sup != m_sup) begin
                    a_old = m_act; m_act = m_oth; m_oth = a_old; m_sup = mode_sup;
                end
                if (dbg_we && !dbg_sel)  m_act = dbg_wdata;   // R7
                else if (core_we)        m_act = core_wdata;  // R3
                if (dbg_we && dbg_sel)   m_oth = dbg_wdata;   // R6, R8
                @(negedge clk);
                if (dbg_we && !dbg_sel && core_we) tag = "R7 core_rdata";
                else if (mode_stb && c[0])         tag = "R9 core_rdata";
                else if (core_we)                  tag = "R3 core_rdata";
                else                               tag = "R4 core_rdata";
                check(tag, core_rdata, m_act);
                check(mode_stb ? "R4 sup_o" : "R5 sup_o", {31'b0, sup_o}, {31'b0, m_sup});
                if (dbg_sel) tag = (dbg_we && core_we) ? "R8 dbg_rdata" : "R6 dbg_rdata";
                else         tag = "R10 dbg_rdata";
                check(tag, dbg_rdata, dbg_sel ? m_oth : m_act);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule